// File: doc/BRIEF.md
# Sensor Conditioner Startup and Mode Controller

This block is the top-level sequencer of a bridge-sensor signal conditioner. After the power-on reset releases, it walks through the power-up phases. First the configuration memory is read and its signature is checked. An optional ROM check may follow. Then the start routine runs, and the block settles into one of three operating modes: continuous conditioning (normal), calibration command mode, or diagnostic mode. Any detected fault drops the block into diagnostic mode. On entry it pulses a strobe that loads an error code into the serial output registers.

The block also decides the drive state of the pin shared by the analog output and the one-wire link. That choice follows a 2-bit output/communication setting. A window timer starts when reset releases and limits when a command-mode request may be accepted in the two windowed settings. The one-wire decoder supplies the request and exit pulses, and the analog path consumes the pin state. Both of those neighbours lie outside this block.

Top module: `sensor_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `pin_state` is tri-state (0) and `mode` is startup (0). The encodings are: `pin_state` 0 tri-state, 1 forced low, 2 active; `mode` 0 startup, 1 normal, 2 command, 3 diagnostic.
- R2: After reset releases and until `cfg_done` is seen, the pin is forced low and `mode` stays startup.
- R3: When `rom_chk_en` is set while the configuration passes, the pin stays forced low for exactly `ROM_CYCLES` cycles of ROM check. The start routine follows if `rom_ok` is high. Otherwise the block enters diagnostic mode with error code `NERR+2`.
- R4: If the signature is bad when `cfg_done` is seen, the block goes straight to diagnostic mode with error code `NERR+1` and skips the start routine.
- R5: During the start routine the pin is forced low for `out_mode` 0 (analog only) and 3 (analog early, overdriven by the master). It is tri-state for `out_mode` 1 (communication only) and 2 (analog after window).
- R6: In normal mode the pin is active for `out_mode` 0 and 3 and tri-state for `out_mode` 1. For `out_mode` 2 it is tri-state while the window is open and active once `WIN_CYCLES` cycles have passed since reset release.
- R7: `cmd_req` is never accepted in `out_mode` 0 and is always accepted in `out_mode` 1. In `out_mode` 2 and 3 it is accepted only while the window is open.
- R8: In command mode the pin is tri-state and the error flags are ignored. The block leaves command mode only on `cmd_exit`, and it always returns to normal mode.
- R9: Any set bit of `err_flags` during the start routine or normal mode moves the block to diagnostic mode and forces the pin low. In the same cycle `err_load` pulses for one cycle. The accompanying `err_code` is the lowest set flag index plus one.
- R10: Diagnostic mode is left only through reset or an accepted `cmd_req`, which leads to command mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| out_mode | input | 2 | Output/communication setting |
| cfg_done | input | 1 | Configuration readout finished |
| cfg_sig_ok | input | 1 | Configuration signature matched |
| rom_chk_en | input | 1 | Run ROM check after readout |
| rom_ok | input | 1 | ROM check result, sampled at its end |
| start_done | input | 1 | Start routine finished |
| cmd_req | input | 1 | Decoded command-mode request pulse |
| cmd_exit | input | 1 | Decoded command-mode exit pulse |
| err_flags | input | NERR | Fault flags (watchdog, oscillator, sensor connection/short, memory integrity) |
| mode | output | 2 | Operating mode |
| pin_state | output | 2 | Shared pin drive state |
| err_load | output | 1 | One-cycle error-code load strobe |
| err_code | output | $clog2(NERR+3) | Error code captured with the strobe |

## Verification
The bench walks through every output setting and checks the pin during the start routine and again in normal mode. A design that swapped the start-phase drive would short the external master or the analog path. The ROM check length is measured to the exact cycle: an off-by-one counter would release the pin one cycle early or late. Command requests are sent inside and after the window, and also in analog-only mode. A design with a wrong window compare would let a late request in, or lock the master out. Error priority is checked, along with error flags raised during command mode and the stickiness of diagnostic mode. A design getting these wrong would report the wrong code, or drop out of calibration or diagnostic mode on its own.

// File: rtl/sensor_mode_ctrl.sv
module sensor_mode_ctrl #(
  parameter int NERR       = 4,
  parameter int WIN_CYCLES = 1500000,
  parameter int ROM_CYCLES = 28180,
  localparam int CODE_W    = $clog2(NERR + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        out_mode,
  input  logic              cfg_done,
  input  logic              cfg_sig_ok,
  input  logic              rom_chk_en,
  input  logic              rom_ok,
  input  logic              start_done,
  input  logic              cmd_req,
  input  logic              cmd_exit,
  input  logic [NERR-1:0]   err_flags,
  output logic [1:0]        mode,
  output logic [1:0]        pin_state,
  output logic              err_load,
  output logic [CODE_W-1:0] err_code
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);
  localparam int ROM_W = $clog2(ROM_CYCLES);
  localparam logic [1:0] PIN_TRI = 2'd0, PIN_LOW = 2'd1, PIN_ACT = 2'd2;

  typedef enum logic [2:0] {ST_CFG, ST_ROM, ST_START, ST_NORM, ST_CMD, ST_DIAG} st_t;
  st_t st, st_n;

  logic [WIN_W-1:0]  win_cnt;
  logic [ROM_W-1:0]  rom_cnt;
  logic              win_open, cmd_ok, load_n;
  logic [CODE_W-1:0] code_n, flag_code;

  assign win_open = win_cnt < WIN_W'(WIN_CYCLES);
  assign cmd_ok   = cmd_req && (out_mode == 2'b01 || (out_mode[1] && win_open));

  always_comb begin
    flag_code = '0;
    for (int i = NERR - 1; i >= 0; i--)
      if (err_flags[i]) flag_code = CODE_W'(i + 1);
  end

  always_comb begin
    st_n   = st;
    load_n = 1'b0;
    code_n = err_code;
    case (st)
      ST_CFG:
        if (cfg_done) begin
          if (!cfg_sig_ok) begin
            st_n = ST_DIAG; load_n = 1'b1; code_n = CODE_W'(NERR + 1);
          end else begin
            st_n = rom_chk_en ? ST_ROM : ST_START;
          end
        end
      ST_ROM:
        if (rom_cnt == ROM_W'(ROM_CYCLES - 1)) begin
          if (rom_ok) st_n = ST_START;
          else begin
            st_n = ST_DIAG; load_n = 1'b1; code_n = CODE_W'(NERR + 2);
          end
        end
      ST_START, ST_NORM:
        if (|err_flags) begin
          st_n = ST_DIAG; load_n = 1'b1; code_n = flag_code;
        end else if (cmd_ok)
          st_n = ST_CMD;
        else if (st == ST_START && start_done)
          st_n = ST_NORM;
      ST_CMD:  if (cmd_exit) st_n = ST_NORM;
      ST_DIAG: if (cmd_ok) st_n = ST_CMD;
      default: st_n = ST_CFG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_CFG;
      win_cnt  <= '0;
      rom_cnt  <= '0;
      err_load <= 1'b0;
      err_code <= '0;
    end else begin
      st       <= st_n;
      err_load <= load_n;
      err_code <= code_n;
      if (win_open) win_cnt <= win_cnt + 1'b1;
      rom_cnt  <= (st == ST_ROM) ? rom_cnt + 1'b1 : '0;
    end
  end

  always_comb begin
    case (st)
      ST_START: pin_state = (out_mode == 2'b00 || out_mode == 2'b11) ? PIN_LOW : PIN_TRI;
      ST_NORM:
        case (out_mode)
          2'b01:   pin_state = PIN_TRI;
          2'b10:   pin_state = win_open ? PIN_TRI : PIN_ACT;
          default: pin_state = PIN_ACT;
        endcase
      ST_CMD:  pin_state = PIN_TRI;
      default: pin_state = PIN_LOW;
    endcase
    if (!rst_n) pin_state = PIN_TRI;
  end

  always_comb begin
    case (st)
      ST_NORM: mode = 2'd1;
      ST_CMD:  mode = 2'd2;
      ST_DIAG: mode = 2'd3;
      default: mode = 2'd0;
    endcase
  end
endmodule

// File: rtl/sensor_mode_ctrl_chk.sv
module sensor_mode_ctrl_chk #(
  parameter int WIN_CYCLES = 1500000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] out_mode,
  input logic       cmd_exit,
  input logic [1:0] mode,
  input logic [1:0] pin_state,
  input logic       err_load
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst < CW'(WIN_CYCLES)) since_rst <= since_rst + 1'b1;

  // R9
  err_strobe_in_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_load |-> mode == 2'd3);

  // R9
  diag_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 |-> pin_state == 2'd1);

  // R8
  cmd_pin_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> pin_state == 2'd0);

  // R8
  cmd_exit_to_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && mode != 2'd2) |-> (mode == 2'd1 && $past(cmd_exit)));

  // R7
  analog_only_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != 2'd2 && mode == 2'd2) |-> $past(out_mode) != 2'b00);

  // R7
  window_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != 2'd2 && mode == 2'd2 && $past(out_mode[1])) |-> $past(since_rst) < CW'(WIN_CYCLES));

  // R6
  normal_not_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 |-> pin_state != 2'd1);

  // R10
  diag_exit_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd3 && mode != 2'd3) |-> mode == 2'd2);
endmodule

bind sensor_mode_ctrl sensor_mode_ctrl_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_mode(out_mode), .cmd_exit(cmd_exit),
  .mode(mode), .pin_state(pin_state), .err_load(err_load)
);

// File: tb/tb_sensor_mode_ctrl.sv
`timescale 1ns/1ps
module tb_sensor_mode_ctrl;
  localparam int NERR = 4, WIN = 300, ROMC = 40;
  localparam int CODE_W = $clog2(NERR + 3);

  logic clk = 0, rst_n = 0;
  logic [1:0] out_mode = 0;
  logic cfg_done = 0, cfg_sig_ok = 0, rom_chk_en = 0, rom_ok = 0, start_done = 0;
  logic cmd_req = 0, cmd_exit = 0;
  logic [NERR-1:0] err_flags = 0;
  logic [1:0] mode, pin_state;
  logic err_load;
  logic [CODE_W-1:0] err_code;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sensor_mode_ctrl #(.NERR(NERR), .WIN_CYCLES(WIN), .ROM_CYCLES(ROMC)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic boot_reset(input logic [1:0] om);
    rst_n = 0; cfg_done = 0; cfg_sig_ok = 0; rom_chk_en = 0; rom_ok = 0;
    start_done = 0; cmd_req = 0; cmd_exit = 0; err_flags = 0; out_mode = om;
    step(3);
    chk("R1 pin", pin_state, 0);
    chk("R1 mode", mode, 0);
    rst_n = 1;
    step(1);
    chk("R2 pin", pin_state, 1);
    chk("R2 mode", mode, 0);
  endtask

  task automatic cfg_pass();
    cfg_done = 1; cfg_sig_ok = 1; step(1); cfg_done = 0;
  endtask

  task automatic to_normal(input logic [1:0] om);
    boot_reset(om); cfg_pass();
    start_done = 1; step(1); start_done = 0;
    chk("R6 mode", mode, 1);
  endtask

  task automatic pulse_cmd();
    cmd_req = 1; step(1); cmd_req = 0;
  endtask

  task automatic t_rom_ok();
    boot_reset(2'b01); rom_chk_en = 1; rom_ok = 1; cfg_pass();
    step(ROMC - 1);
    chk("R3 rom pin low", pin_state, 1);
    step(1);
    chk("R3 after rom pin", pin_state, 0);
    chk("R3 after rom mode", mode, 0);
  endtask

  task automatic t_rom_fail();
    boot_reset(2'b00); rom_chk_en = 1; rom_ok = 0; cfg_pass();
    step(ROMC - 1);
    chk("R3 still rom", mode, 0);
    step(1);
    chk("R3 fail mode", mode, 3);
    chk("R3 fail load", err_load, 1);
    chk("R3 fail code", err_code, NERR + 2);
    step(1);
    chk("R3 load pulse", err_load, 0);
  endtask

  task automatic t_sig_fail();
    boot_reset(2'b10); cfg_done = 1; cfg_sig_ok = 0; step(1); cfg_done = 0;
    chk("R4 mode", mode, 3);
    chk("R4 pin", pin_state, 1);
    chk("R4 load", err_load, 1);
    chk("R4 code", err_code, NERR + 1);
    start_done = 1; step(2); start_done = 0;
    chk("R4 no start", mode, 3);
  endtask

  task automatic t_pins();
    for (int om = 0; om < 4; om++) begin
      boot_reset(2'(om)); cfg_pass();
      chk("R5 start pin", pin_state, (om == 0 || om == 3) ? 1 : 0);
      start_done = 1; step(1); start_done = 0;
      chk("R6 normal pin", pin_state, (om == 1 || om == 2) ? 0 : 2);
    end
    step(WIN);
    chk("R6 window over pin", pin_state, 2);
  endtask

  task automatic t_cmd_window();
    to_normal(2'b00); pulse_cmd();
    chk("R7 analog-only reject", mode, 1);
    chk("R7 analog-only pin", pin_state, 2);
    to_normal(2'b10); step(WIN + 20); pulse_cmd();
    chk("R7 late reject", mode, 1);
    to_normal(2'b01); step(WIN + 20); pulse_cmd();
    chk("R7 comm-only accept", mode, 2);
    to_normal(2'b11); pulse_cmd();
    chk("R7 early accept", mode, 2);
    chk("R8 cmd pin", pin_state, 0);
    err_flags = 4'b0001; step(3); err_flags = 0;
    chk("R8 errors ignored", mode, 2);
    cmd_exit = 1; step(1); cmd_exit = 0;
    chk("R8 exit mode", mode, 1);
    chk("R8 exit pin", pin_state, 2);
  endtask

  task automatic t_errors();
    to_normal(2'b01);
    err_flags = 4'b1100; step(1); err_flags = 0;
    chk("R9 mode", mode, 3);
    chk("R9 pin", pin_state, 1);
    chk("R9 load", err_load, 1);
    chk("R9 code", err_code, 3);
    step(5);
    chk("R10 sticky", mode, 3);
    chk("R9 code held", err_code, 3);
    pulse_cmd();
    chk("R10 cmd exit", mode, 2);
    boot_reset(2'b00); cfg_pass();
    err_flags = 4'b0010; step(1); err_flags = 0;
    chk("R9 start err mode", mode, 3);
    chk("R9 start err code", err_code, 2);
    pulse_cmd();
    chk("R10 analog-only stays", mode, 3);
  endtask

  initial begin
    t_rom_ok();
    t_rom_fail();
    t_sig_fail();
    t_pins();
    t_cmd_window();
    t_errors();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule